// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block chooses the feedback multiplier M and the input divider N of a PLL so that the PLL output lands as close as it can to a requested frequency. The caller presents a reference clock frequency and a per-lane data rate, both in kHz, and pulses a start strobe. The target output frequency is half the data rate. The block then walks the legal input dividers one at a time. For each N it computes a rounded M and the output frequency that M actually produces. It drops candidates that break the multiplier or output limits and keeps the candidate with the smallest absolute frequency error.

Every division runs on a shared restoring divider that resolves one quotient bit per cycle. Each candidate N therefore costs two divisions. A search over the widest window takes about a thousand cycles. When the search ends, the block pulses a done strobe and presents M, N, the achieved frequency and a success flag. These values stay unchanged until the next search completes.

Top module: `pll_search`

## Requirements
- R1: A data rate below 80000 kHz or above 2500000 kHz makes the block report failure without searching. Done rises no more than 3 cycles after the start pulse is sampled.
- R2: A reference frequency below 2000 kHz or above 64000 kHz makes the block report failure without searching, within the same latency as R1.
- R3: The target output frequency is floor(rate / 2). The post divider is 8 / min(ceil(target / 80000), 8), which always gives 1, 2, 4 or 8.
- R4: The candidate dividers run from ceil(fref / 8000) to floor(fref / 2000). Both limits are clamped to the range 1 to 16.
- R5: For each N, M = floor((2·target·N·div + fref) / (2·fref)), which is round-half-up. A candidate with M outside 64 to 625 is dropped.
- R6: The achieved frequency is floor(M·fref / (N·div)). A candidate whose achieved frequency lies outside 40000 to 1250000 kHz is dropped.
- R7: The reported candidate has the smallest |target − achieved|. A later N replaces the kept candidate only on a strictly smaller error, so the lowest N wins a tie.
- R8: done_o is high for exactly one cycle per search. m_o, n_o, fout_o and ok_o change only in that cycle and hold their values afterwards.
- R9: Start and the input values are sampled only while busy_o is low. A start pulse or an input change during a search does not affect its result.
- R10: A search that fails, whether by rejected inputs or because no candidate survives, reports ok_o = 0 with m_o, n_o and fout_o all zero.
- R11: After reset, busy_o, done_o and ok_o are low and m_o, n_o and fout_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| fref_i | input | FREQ_W | Reference frequency in kHz |
| rate_i | input | RATE_W | Per-lane data rate in kHz |
| busy_o | output | 1 | High from the accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | A valid M/N pair was found |
| m_o | output | M_W | Feedback multiplier |
| n_o | output | N_W | Input divider |
| fout_o | output | RATE_W-1 | Achieved output frequency in kHz |

## Verification
The hardest case to provoke from the ports is a search in which the first dividers of the window are rejected before any candidate survives. That path is the only one that exercises the M floor and the handling of an empty kept candidate. The stimulus reaches it with a 64000 kHz reference at the lowest legal rate. There the clamped window is 8 to 16, and N = 8 to 12 all produce M below 64. A second hard case is a start pulse arriving mid-search together with different inputs. The bench raises start ten cycles into a long search and checks that the result still belongs to the first request.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned RATE_MIN_KHZ = 80000;
  localparam int unsigned RATE_MAX_KHZ = 2500000;
  localparam int unsigned FREF_MIN_KHZ = 2000;
  localparam int unsigned FREF_MAX_KHZ = 64000;
  localparam int unsigned PFD_MIN_KHZ  = 2000;
  localparam int unsigned PFD_MAX_KHZ  = 8000;
  localparam int unsigned BAND_KHZ     = 80000;
  localparam int unsigned MUL_MIN      = 64;
  localparam int unsigned MUL_MAX      = 625;
  localparam int unsigned NDIV_MAX     = 16;
  localparam int unsigned OUT_MIN_KHZ  = 40000;
  localparam int unsigned OUT_MAX_KHZ  = 1250000;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_LAUNCH_M, S_WAIT_M, S_LAUNCH_F, S_WAIT_F, S_NEXT, S_DONE
  } srch_state_e;
endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  q_q, r_q, dvs_q;
  logic          done_q;
  logic [W:0]    rs, diff;

  assign rs   = {r_q, q_q[W-1]};
  assign diff = rs - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      q_q    <= '0;
      r_q    <= '0;
      dvs_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(W);
      q_q    <= dividend_i;
      r_q    <= '0;
      dvs_q  <= divisor_i;
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
      if (!diff[W]) begin
        r_q <= diff[W-1:0];
        q_q <= {q_q[W-2:0], 1'b1};
      end else begin
        r_q <= rs[W-1:0];
        q_q <= {q_q[W-2:0], 1'b0};
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/pll_search_setup.sv
module pll_search_setup
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 17,
  parameter int RATE_W = 22,
  parameter int N_W    = 5
) (
  input  logic [FREQ_W-1:0] fref_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [RATE_W-2:0] target_o,
  output logic [1:0]        div_sh_o,
  output logic [N_W-1:0]    n_lo_o,
  output logic [N_W-1:0]    n_hi_o,
  output logic              legal_o
);
  localparam int FOUT_W = RATE_W - 1;

  logic rate_ok, fref_ok;

  assign target_o = rate_i[RATE_W-1:1];
  assign rate_ok  = (int'(rate_i) >= RATE_MIN_KHZ) && (int'(rate_i) <= RATE_MAX_KHZ);
  assign fref_ok  = (int'(fref_i) >= FREF_MIN_KHZ) && (int'(fref_i) <= FREF_MAX_KHZ);

  // post divider 8/min(ceil(t/band),8) as a shift: 8,4,2,1
  always_comb begin
    if (int'(target_o) <= BAND_KHZ)          div_sh_o = 2'd3;
    else if (int'(target_o) <= 2 * BAND_KHZ) div_sh_o = 2'd2;
    else if (int'(target_o) <= 4 * BAND_KHZ) div_sh_o = 2'd1;
    else                                     div_sh_o = 2'd0;
  end

  // ceil/floor of fref over the PFD limits, clamped to 1..NDIV_MAX
  always_comb begin
    n_lo_o = N_W'(1);
    n_hi_o = N_W'(1);
    for (int k = 1; k < NDIV_MAX; k++)
      if (int'(fref_i) > k * PFD_MAX_KHZ) n_lo_o = N_W'(k + 1);
    for (int k = 2; k <= NDIV_MAX; k++)
      if (int'(fref_i) >= k * PFD_MIN_KHZ) n_hi_o = N_W'(k);
  end

  assign legal_o = rate_ok && fref_ok && (n_lo_o <= n_hi_o) && (FOUT_W > 0);
endmodule

// File: rtl/pll_search.sv
module pll_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 17,
  parameter int RATE_W = 22,
  parameter int M_W    = 10,
  parameter int N_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] fref_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [RATE_W-2:0] fout_o
);
  localparam int FOUT_W = RATE_W - 1;
  localparam int DIV_W  = FOUT_W + N_W + 4;

  srch_state_e state_q;
  logic [FREQ_W-1:0] fref_q;
  logic [RATE_W-1:0] rate_q;
  logic [N_W-1:0]    n_q;
  logic [M_W-1:0]    m_q;

  logic [FOUT_W-1:0] target;
  logic [1:0]        div_sh;
  logic [N_W-1:0]    n_lo, n_hi;
  logic              legal;

  logic              best_vld_q;
  logic [M_W-1:0]    best_m_q;
  logic [N_W-1:0]    best_n_q;
  logic [FOUT_W-1:0] best_f_q, best_err_q;

  logic              ok_q;
  logic [M_W-1:0]    m_res_q;
  logic [N_W-1:0]    n_res_q;
  logic [FOUT_W-1:0] f_res_q;

  logic             div_go, div_done;
  logic [DIV_W-1:0] div_a, div_b, quot;
  logic [DIV_W-1:0] prod_tn;
  logic [FOUT_W-1:0] f_cand, f_err;
  logic             m_fits, f_fits;

  pll_search_setup #(.FREQ_W(FREQ_W), .RATE_W(RATE_W), .N_W(N_W)) u_setup (
    .fref_i   (fref_q),
    .rate_i   (rate_q),
    .target_o (target),
    .div_sh_o (div_sh),
    .n_lo_o   (n_lo),
    .n_hi_o   (n_hi),
    .legal_o  (legal)
  );

  assign prod_tn = DIV_W'(target) * DIV_W'(n_q);
  assign div_go  = (state_q == S_LAUNCH_M) || (state_q == S_LAUNCH_F);

  always_comb begin
    if (state_q == S_LAUNCH_F) begin
      div_a = DIV_W'(m_q) * DIV_W'(fref_q);
      div_b = DIV_W'(n_q) << div_sh;
    end else begin
      // round-half-up: (2*t*n*div + fref) / (2*fref)
      div_a = (prod_tn << ({1'b0, div_sh} + 3'd1)) + DIV_W'(fref_q);
      div_b = DIV_W'(fref_q) << 1;
    end
  end

  pll_search_div #(.W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_go),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  assign m_fits = (quot >= DIV_W'(MUL_MIN)) && (quot <= DIV_W'(MUL_MAX));
  assign f_fits = (quot >= DIV_W'(OUT_MIN_KHZ)) && (quot <= DIV_W'(OUT_MAX_KHZ));
  assign f_cand = quot[FOUT_W-1:0];
  assign f_err  = (target > f_cand) ? (target - f_cand) : (f_cand - target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      fref_q     <= '0;
      rate_q     <= '0;
      n_q        <= '0;
      m_q        <= '0;
      best_vld_q <= 1'b0;
      best_m_q   <= '0;
      best_n_q   <= '0;
      best_f_q   <= '0;
      best_err_q <= '1;
      ok_q       <= 1'b0;
      m_res_q    <= '0;
      n_res_q    <= '0;
      f_res_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          fref_q  <= fref_i;
          rate_q  <= rate_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          best_vld_q <= 1'b0;
          best_err_q <= '1;
          n_q        <= n_lo;
          if (legal) state_q <= S_LAUNCH_M;
          else begin
            ok_q    <= 1'b0;
            m_res_q <= '0;
            n_res_q <= '0;
            f_res_q <= '0;
            state_q <= S_DONE;
          end
        end
        S_LAUNCH_M: state_q <= S_WAIT_M;
        S_WAIT_M: if (div_done) begin
          m_q     <= quot[M_W-1:0];
          state_q <= m_fits ? S_LAUNCH_F : S_NEXT;
        end
        S_LAUNCH_F: state_q <= S_WAIT_F;
        S_WAIT_F: if (div_done) begin
          if (f_fits && (!best_vld_q || f_err < best_err_q)) begin
            best_vld_q <= 1'b1;
            best_m_q   <= m_q;
            best_n_q   <= n_q;
            best_f_q   <= f_cand;
            best_err_q <= f_err;
          end
          state_q <= S_NEXT;
        end
        S_NEXT: begin
          if (n_q == n_hi) begin
            ok_q    <= best_vld_q;
            m_res_q <= best_vld_q ? best_m_q : '0;
            n_res_q <= best_vld_q ? best_n_q : '0;
            f_res_q <= best_vld_q ? best_f_q : '0;
            state_q <= S_DONE;
          end else begin
            n_q     <= n_q + 1'b1;
            state_q <= S_LAUNCH_M;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign ok_o   = ok_q;
  assign m_o    = m_res_q;
  assign n_o    = n_res_q;
  assign fout_o = f_res_q;
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk
  import pll_search_pkg::*;
#(
  parameter int M_W    = 10,
  parameter int N_W    = 5,
  parameter int FOUT_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic [M_W-1:0]    m_o,
  input logic [N_W-1:0]    n_o,
  input logic [FOUT_W-1:0] fout_o
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ok_o, m_o, n_o, fout_o}) |-> done_o);

  a_r9_accept_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r5_m_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (int'(m_o) >= MUL_MIN && int'(m_o) <= MUL_MAX));

  a_r4_n_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (int'(n_o) >= 1 && int'(n_o) <= NDIV_MAX));

  a_r6_fout_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (int'(fout_o) >= OUT_MIN_KHZ && int'(fout_o) <= OUT_MAX_KHZ));

  a_r10_fail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> (m_o == '0 && n_o == '0 && fout_o == '0));
endmodule

bind pll_search pll_search_chk #(.M_W(M_W), .N_W(N_W), .FOUT_W(RATE_W - 1)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ok_o    (ok_o),
  .m_o     (m_o),
  .n_o     (n_o),
  .fout_o  (fout_o)
);

// File: tb/tb_pll_search.sv
`timescale 1ns/1ps
module tb_pll_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] fref = '0;
  logic [21:0] rate = '0;
  logic        busy, done, ok;
  logic [9:0]  m;
  logic [4:0]  n;
  logic [20:0] fout;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pll_search dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .fref_i (fref), .rate_i (rate),
    .busy_o (busy), .done_o (done), .ok_o (ok),
    .m_o (m), .n_o (n), .fout_o (fout)
  );

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input longint fin, input longint dr,
                       output bit e_ok, output longint e_m, output longint e_n, output longint e_f);
    longint t, c, dv, lo, hi, mm, ff, er, best;
    e_ok = 0; e_m = 0; e_n = 0; e_f = 0; best = -1;
    if (dr < 80000 || dr > 2500000 || fin < 2000 || fin > 64000) return;
    t  = dr / 2;
    c  = (t + 79999) / 80000;
    if (c > 8) c = 8;
    dv = 8 / c;
    lo = (fin + 7999) / 8000;
    hi = fin / 2000;
    if (lo < 1) lo = 1;
    if (lo > 16) lo = 16;
    if (hi < 1) hi = 1;
    if (hi > 16) hi = 16;
    for (longint k = lo; k <= hi; k++) begin
      mm = (2 * t * k * dv + fin) / (2 * fin);
      if (mm < 64 || mm > 625) continue;
      ff = (mm * fin) / (k * dv);
      if (ff < 40000 || ff > 1250000) continue;
      er = (t > ff) ? t - ff : ff - t;
      if (best < 0 || er < best) begin
        best = er; e_ok = 1; e_m = mm; e_n = k; e_f = ff;
      end
    end
  endtask

  task automatic launch(input int fin, input int dr);
    @(negedge clk);
    fref = 17'(fin); rate = 22'(dr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 6000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic compare(input string req, input int fin, input int dr);
    bit e_ok; longint e_m, e_n, e_f;
    model(fin, dr, e_ok, e_m, e_n, e_f);
    check(done == 1'b1, {req, " done"}, done, 1);
    check(ok == e_ok, {req, " ok"}, ok, e_ok);
    check(m == e_m, {req, " m"}, m, e_m);
    check(n == e_n, {req, " n"}, n, e_n);
    check(fout == e_f, {req, " fout"}, fout, e_f);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  task automatic run_case(input string req, input int fin, input int dr);
    int lat;
    launch(fin, dr);
    wait_done(lat);
    compare(req, fin, dr);
  endtask

  task automatic t_reset();
    check(busy == 0, "R11 busy", busy, 0);
    check(done == 0, "R11 done", done, 0);
    check(ok == 0, "R11 ok", ok, 0);
    check({m, n, fout} == '0, "R11 outputs", {m, n, fout}, 0);
  endtask

  task automatic t_bad_rate();
    int lat;
    launch(24000, 79999);
    wait_done(lat);
    check(lat <= 3, "R1 low rate latency", lat, 3);
    compare("R1 R10 rate low", 24000, 79999);
    launch(24000, 2500001);
    wait_done(lat);
    check(lat <= 3, "R1 high rate latency", lat, 3);
    compare("R1 R10 rate high", 24000, 2500001);
  endtask

  task automatic t_bad_fref();
    int lat;
    launch(1999, 1000000);
    wait_done(lat);
    check(lat <= 3, "R2 fref latency", lat, 3);
    compare("R2 R10 fref low", 1999, 1000000);
    launch(64001, 1000000);
    wait_done(lat);
    compare("R2 R10 fref high", 64001, 1000000);
  endtask

  task automatic t_bands();
    run_case("R3 R5 R6 div1", 24000, 1000000);
    check(m == 125 && n == 6, "R7 exact hit n6", n, 6);
    run_case("R3 div2", 24000, 500000);
    run_case("R3 div4", 24000, 300000);
    run_case("R3 div4 low", 27000, 200000);
    run_case("R3 div8", 19200, 100000);
    run_case("R3 band edge", 26000, 160000);
    run_case("R3 band edge+1", 26000, 160002);
  endtask

  task automatic t_window();
    run_case("R4 R5 clamp and M floor", 64000, 80000);
    run_case("R4 single n", 2000, 2500000);
    run_case("R4 narrow", 7999, 1234566);
    run_case("R6 R7 odd fref", 33333, 1777777);
    run_case("R7 tie lowest n", 12000, 250002);
    run_case("R1 rate bounds", 38400, 80000);
    run_case("R1 rate top", 38400, 2500000);
  endtask

  task automatic t_ignore_start();
    int lat;
    bit e_ok; longint e_m, e_n, e_f;
    launch(64000, 1500000);
    repeat (10) @(negedge clk);
    check(busy == 1, "R9 busy during search", busy, 1);
    fref = 17'd19200; rate = 22'd300000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    compare("R9 ignored start", 64000, 1500000);
    model(64000, 1500000, e_ok, e_m, e_n, e_f);
    repeat (20) @(negedge clk);
    check(busy == 0, "R9 no second search", busy, 0);
    check(m == e_m && n == e_n && fout == e_f, "R8 outputs held", fout, e_f);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_rate();
    t_bad_fref();
    t_bands();
    t_window();
    t_ignore_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule